// File: doc/BRIEF.md
# Conditional Instruction Action Sequencer

This block is the control unit of a small microcontroller core. Once an instruction has been decoded, the block receives its class code and a `go` request. It then drives start strobes to three datapath units: the fetch unit, the program-counter incrementer and the ALU. Each unit answers every start with a one-cycle done pulse. The schedule for each class is a partial order: a step may start several units together, and the next step begins only when every unit started in the current step has answered.

For the conditional immediate class, the first step is a compare on the ALU, run together with a program-counter increment. The less-than flag that the compare produces decides the rest of the schedule. If the flag is set, the block fetches the operand, runs the ALU together with a second increment, and then fetches the next instruction. If the flag is clear, the operand fetch and the second ALU action are left out. A single-cycle completion pulse marks the end of every instruction.

Top module: `act_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every start strobe and the completion pulse are low.
- R2: Class code 0 (ALU register to register) issues the steps {ALU, PCINC} and then {FETCH}.
- R3: Class code 1 (ALU immediate to register) issues the steps {PCINC}, {FETCH}, {ALU, PCINC} and {FETCH}, in that order.
- R4: Class code 2 (conditional ALU immediate) always opens with the step {ALU, PCINC}.
- R5: For class code 2 with the flag set, the opening step is followed by {FETCH}, {ALU, PCINC} and {FETCH}.
- R6: For class code 2 with the flag clear, the opening step is followed by {PCINC} and {FETCH} only, and no further ALU start is issued.
- R7: The flag is sampled on the clock edge at which the opening step of class code 2 completes. Its value at any other time has no effect on the schedule.
- R8: Every unit in a step is started in the same cycle. The next step starts only after each of those units has returned done, and the done pulses may arrive in any order and in any cycle, including the cycle of the start.
- R9: Start strobes are registered. The first step appears in the cycle after `go` is accepted, and each later step appears in the cycle after the edge at which the last outstanding done was sampled.
- R10: The completion pulse is high for exactly one cycle per instruction, in the cycle after the edge that samples the done of the final step.
- R11: A `go` that arrives while an instruction is in progress is ignored and leaves the running schedule unchanged.
- R12: A `go` with class code 3 is ignored. No strobe and no completion pulse follow.
- R13: A done pulse from a unit with no outstanding start is ignored.

Strobe and done vectors use bit 0 for the fetch unit (FETCH), bit 1 for the program-counter incrementer (PCINC) and bit 2 for the ALU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Request to run the instruction in `cls` (accepted only when idle) |
| cls | input | 2 | Instruction class code (0, 1, 2 valid; 3 reserved) |
| lt | input | 1 | Less-than flag produced by the compare step |
| unit_done | input | 3 | Per-unit done pulses (bit 0 FETCH, bit 1 PCINC, bit 2 ALU) |
| unit_start | output | 3 | Per-unit start strobes (same bit order) |
| instr_done | output | 1 | One-cycle instruction-complete pulse |

## Verification
The bench answers each strobe after a random latency of zero to three cycles, so the done pulses of a concurrent step arrive in varying orders. A sequencer that advanced on the first done, rather than on the last, would issue a step too early, and the bench would see a shorter or reordered set of strobes. Once the opening step has completed, the bench inverts the flag. A design that sampled the flag late, or did not hold it, would then take the wrong branch: it would either issue an extra ALU start or leave out the operand fetch. In the noisy runs the bench also sends mid-instruction `go` pulses and stray done pulses, and it issues reserved class codes. A sequencer that failed to ignore any of these would restart, skip ahead, or produce strobes where none are expected.

// File: rtl/act_seq_pkg.sv
package act_seq_pkg;
  localparam int N_UNIT = 3;
  localparam int U_FETCH = 0;
  localparam int U_PCINC = 1;
  localparam int U_ALU   = 2;

  typedef logic [N_UNIT-1:0] umask_t;

  localparam umask_t M_FETCH = umask_t'(1 << U_FETCH);
  localparam umask_t M_PCINC = umask_t'(1 << U_PCINC);
  localparam umask_t M_ALU   = umask_t'(1 << U_ALU);

  typedef enum logic [1:0] {
    CLS_ALU_RR   = 2'd0,
    CLS_ALU_IMM  = 2'd1,
    CLS_CALU_IMM = 2'd2,
    CLS_RSVD     = 2'd3
  } cls_e;
endpackage

// File: rtl/act_seq_plan.sv
module act_seq_plan
  import act_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  cls_e              cls,
  input  logic [STEP_W-1:0] step,
  input  logic              lt,
  output umask_t            mask
);
  // Units to start for a given step of a class; zero means the schedule has ended.
  always_comb begin
    mask = '0;
    unique case (cls)
      CLS_ALU_RR: begin
        case (int'(step))
          0:       mask = M_ALU | M_PCINC;
          1:       mask = M_FETCH;
          default: mask = '0;
        endcase
      end
      CLS_ALU_IMM: begin
        case (int'(step))
          0:       mask = M_PCINC;
          1:       mask = M_FETCH;
          2:       mask = M_ALU | M_PCINC;
          3:       mask = M_FETCH;
          default: mask = '0;
        endcase
      end
      CLS_CALU_IMM: begin
        if (lt) begin
          case (int'(step))
            0:       mask = M_ALU | M_PCINC;
            1:       mask = M_FETCH;
            2:       mask = M_ALU | M_PCINC;
            3:       mask = M_FETCH;
            default: mask = '0;
          endcase
        end else begin
          case (int'(step))
            0:       mask = M_ALU | M_PCINC;
            1:       mask = M_PCINC;
            2:       mask = M_FETCH;
            default: mask = '0;
          endcase
        end
      end
      default: mask = '0;
    endcase
  end
endmodule

// File: rtl/act_seq_track.sv
module act_seq_track
  import act_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  umask_t load_mask,
  input  umask_t done,
  output umask_t pend,
  output logic   all_clear
);
  // One outstanding-start flag per unit.
  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    logic pend_d;
    always_comb begin
      pend_d = pend[u];
      if (load)         pend_d = load_mask[u];
      else if (done[u]) pend_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[u] <= 1'b0;
      else        pend[u] <= pend_d;
    end
  end

  // Every outstanding unit has answered by this edge.
  assign all_clear = (pend != '0) && ((pend & ~done) == '0);
endmodule

// File: rtl/act_seq.sv
module act_seq
  import act_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        cls,
  input  logic              lt,
  input  logic [N_UNIT-1:0] unit_done,
  output logic [N_UNIT-1:0] unit_start,
  output logic              instr_done
);
  localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

  logic              busy_q, busy_d;
  cls_e              cls_q, cls_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              lt_q, lt_d;
  umask_t            start_q, start_d;
  logic              cmpl_q, cmpl_d;
  logic              cls_en, step_en, lt_en;

  logic              accept;
  logic              step_end;
  logic              load;
  umask_t            pend;
  logic              all_clear;

  cls_e              plan_cls;
  logic [STEP_W-1:0] plan_step;
  logic              plan_lt;
  umask_t            nxt_mask;

  assign accept   = go && !busy_q && (cls_e'(cls) != CLS_RSVD);
  assign step_end = busy_q && all_clear;

  // Look up the step that follows; the live flag is used only when leaving step 0.
  assign plan_cls  = accept ? cls_e'(cls) : cls_q;
  assign plan_step = accept ? '0 : (step_q + STEP_ONE);
  assign plan_lt   = (step_q == '0) ? lt : lt_q;

  act_seq_plan #(.STEP_W(STEP_W)) u_plan (
    .cls  (plan_cls),
    .step (plan_step),
    .lt   (plan_lt),
    .mask (nxt_mask)
  );

  act_seq_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_mask (start_d),
    .done      (unit_done),
    .pend      (pend),
    .all_clear (all_clear)
  );

  always_comb begin
    busy_d  = busy_q;
    cls_d   = cls_q;
    step_d  = step_q;
    lt_d    = lt_q;
    start_d = '0;
    cmpl_d  = 1'b0;
    cls_en  = 1'b0;
    step_en = 1'b0;
    lt_en   = 1'b0;
    load    = 1'b0;
    if (accept) begin
      busy_d  = 1'b1;
      cls_d   = cls_e'(cls);
      cls_en  = 1'b1;
      step_d  = '0;
      step_en = 1'b1;
      start_d = nxt_mask;
      load    = 1'b1;
    end else if (step_end) begin
      if (nxt_mask == '0) begin
        busy_d = 1'b0;
        cmpl_d = 1'b1;
      end else begin
        step_d  = step_q + STEP_ONE;
        step_en = 1'b1;
        start_d = nxt_mask;
        load    = 1'b1;
        if (step_q == '0) begin
          lt_d  = lt;
          lt_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= '0;
      cmpl_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      cmpl_q  <= cmpl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q  <= CLS_ALU_RR;
      step_q <= '0;
      lt_q   <= 1'b0;
    end else begin
      if (cls_en)  cls_q  <= cls_d;
      if (step_en) step_q <= step_d;
      if (lt_en)   lt_q   <= lt_d;
    end
  end

  assign unit_start = start_q;
  assign instr_done = cmpl_q;
endmodule

// File: rtl/act_seq_chk.sv
module act_seq_chk
  import act_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic [1:0]        cls,
  input logic [N_UNIT-1:0] unit_start,
  input logic [N_UNIT-1:0] unit_done,
  input logic              instr_done,
  input logic              busy,
  input logic [N_UNIT-1:0] pend,
  input logic [1:0]        cls_q,
  input logic [STEP_W-1:0] step_q,
  input logic              lt_q
);
  assert_issue_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_start != '0) |-> ($past(pend & ~unit_done) == '0));

  assert_start_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_start != '0) |-> busy);

  assert_cmpl_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  assert_cmpl_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> (!busy && unit_start == '0));

  assert_busy_go_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  assert_class_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cls_q));

  assert_rsvd_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && cls == 2'd3) |=> (unit_start == '0 && !busy));

  assert_no_alu_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cls_q == 2'd2 && step_q != '0 && !lt_q) |-> !unit_start[U_ALU]);
endmodule

bind act_seq act_seq_chk #(.STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .go         (go),
  .cls        (cls),
  .unit_start (unit_start),
  .unit_done  (unit_done),
  .instr_done (instr_done),
  .busy       (busy_q),
  .pend       (pend),
  .cls_q      (cls_q),
  .step_q     (step_q),
  .lt_q       (lt_q)
);

// File: tb/act_seq_tb.sv
module act_seq_tb;
  logic       clk;
  logic       rst_n;
  logic       go;
  logic [1:0] cls;
  logic       lt;
  logic [2:0] unit_done;
  logic [2:0] unit_start;
  logic       instr_done;

  int vec  = 0;
  int miss = 0;

  act_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .cls        (cls),
    .lt         (lt),
    .unit_done  (unit_done),
    .unit_start (unit_start),
    .instr_done (instr_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe bits: 0 FETCH, 1 PCINC, 2 ALU.
  function automatic int exp_len(input logic [1:0] c, input bit l);
    case (c)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return l ? 4 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] exp_mask(input logic [1:0] c, input bit l, input int i);
    logic [2:0] r;
    r = 3'b000;
    case (c)
      2'd0: r = (i == 0) ? 3'b110 : 3'b001;
      2'd1: case (i) 0: r = 3'b010; 1: r = 3'b001; 2: r = 3'b110; default: r = 3'b001; endcase
      2'd2: begin
        if (l) case (i) 0: r = 3'b110; 1: r = 3'b001; 2: r = 3'b110; default: r = 3'b001; endcase
        else   case (i) 0: r = 3'b110; 1: r = 3'b010; default: r = 3'b001; endcase
      end
      default: r = 3'b000;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] c, input bit l);
    case (c)
      2'd0:    return "R2";
      2'd1:    return "R3";
      default: return l ? "R5/R7" : "R6/R7";
    endcase
  endfunction

  task automatic run_instr(input logic [1:0] c, input bit ltv, input bit noise);
    int         nexp;
    int         nobs;
    int         ndone;
    int         first_cyc;
    int         cmpl_cyc;
    int         last_drv;
    int         cnt[3];
    logic [2:0] obs[8];
    logic [2:0] dn;
    string      rq;
    nexp = exp_len(c, ltv);
    nobs = 0; ndone = 0; first_cyc = -1; cmpl_cyc = -1; last_drv = -1;
    for (int u = 0; u < 3; u++) cnt[u] = 0;
    for (int i = 0; i < 8; i++) obs[i] = 3'b000;
    rq = noise ? {req_of(c, ltv), "/R11/R13"} : req_of(c, ltv);
    @(negedge clk);
    go = 1'b1; cls = c; lt = ltv; unit_done = 3'b000;
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      if (unit_start != 3'b000) begin
        if (nobs < 8) obs[nobs] = unit_start;
        if (nobs == 0) first_cyc = k;
        nobs++;
      end
      if (instr_done) begin
        ndone++;
        cmpl_cyc = k;
      end
      go = 1'b0;
      if (noise && nobs > 0 && nobs < nexp && $urandom_range(0, 3) == 0) begin
        go  = 1'b1;
        cls = 2'($urandom_range(0, 3));
      end
      lt = (nobs >= 2) ? ~ltv : ltv;
      dn = 3'b000;
      for (int u = 0; u < 3; u++)
        if (unit_start[u]) cnt[u] = $urandom_range(1, 4);
      for (int u = 0; u < 3; u++)
        if (cnt[u] > 0) begin
          cnt[u]--;
          if (cnt[u] == 0) begin
            dn[u] = 1'b1;
            if (nobs == nexp) last_drv = k;
          end
        end
      if (noise)
        for (int u = 0; u < 3; u++)
          if (cnt[u] == 0 && !unit_start[u] && !dn[u] && $urandom_range(0, 4) == 0)
            dn[u] = 1'b1;
      unit_done = dn;
      if (ndone > 0 && k >= cmpl_cyc + 2) break;
    end
    go = 1'b0; unit_done = 3'b000;
    chk(nobs == nexp, {rq, " step count"}, nobs, nexp);
    for (int i = 0; i < nexp && i < 8; i++)
      chk(obs[i] == exp_mask(c, ltv, i),
          (i == 0 && c == 2'd2) ? "R4/R8 opening step" : {rq, "/R8 step mask"},
          int'(obs[i]), int'(exp_mask(c, ltv, i)));
    chk(first_cyc == 1, "R9 first strobe timing", first_cyc, 1);
    chk(ndone == 1, "R10 completion pulse count", ndone, 1);
    chk(cmpl_cyc == last_drv + 1, "R10 completion timing", cmpl_cyc, last_drv + 1);
  endtask

  task automatic run_rsvd();
    int ns;
    int nd;
    ns = 0; nd = 0;
    @(negedge clk);
    go = 1'b1; cls = 2'd3;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      go = 1'b0;
      if (unit_start != 3'b000) ns++;
      if (instr_done) nd++;
    end
    chk(ns == 0, "R12 reserved class strobes", ns, 0);
    chk(nd == 0, "R12 reserved class completion", nd, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual hung, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; go = 1'b0; cls = 2'd0; lt = 1'b0; unit_done = 3'b000;
    repeat (3) @(negedge clk);
    chk(unit_start == 3'b000 && !instr_done, "R1 outputs in reset",
        int'({instr_done, unit_start}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(unit_start == 3'b000 && !instr_done, "R1 outputs after reset",
        int'({instr_done, unit_start}), 0);

    run_instr(2'd0, 1'b0, 1'b0);
    run_instr(2'd1, 1'b1, 1'b0);
    run_instr(2'd2, 1'b1, 1'b0);
    run_instr(2'd2, 1'b0, 1'b0);
    run_rsvd();
    run_instr(2'd2, 1'b0, 1'b1);

    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 9) == 0) run_rsvd();
      else run_instr(2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule